// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a two-bank SDRAM from power-on to a usable state. It sits on the controller side of the memory command bus. After reset it keeps the bus idle for a stabilization interval sized from the clock frequency. It then closes every bank, runs a configurable number of auto-refresh cycles and loads the device's mode register from a configuration word. Every command is followed by the recovery time it needs, and the bus is idle during each of those waits.

When the last wait ends, the block raises a completion flag and hands the command bus to the normal memory controller through a grant output. A strap input chosen during reset decides whether the mode register is loaded before the refresh train or after it. Nothing restarts the sequence except another reset.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset release the command bus shows only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). The first other command appears on the STABLE_CYC-th rising clock edge after release, where STABLE_CYC = STABLE_US * CLK_MHZ.
- R2: The close-all-banks command is encoded cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit AP_BIT (default 10) high and every other address bit low. It is issued exactly once per sequence, and it is the first command.
- R3: Auto-refresh is encoded cs_n=0, ras_n=0, cas_n=0, we_n=1, with the address all zero. Exactly N_REFRESH refreshes are issued per sequence. Two consecutive refreshes are T_RC rising edges apart.
- R4: The mode-register load is encoded cs_n=0, ras_n=0, cas_n=0, we_n=0. It carries mode_cfg on the address bus and bank bit ba=0, and it is issued exactly once per sequence.
- R5: With mrs_first=0 at reset, the order is close-all, the refreshes, then the mode load. The gaps are T_RP edges from close-all to the first refresh, T_RC edges from the last refresh to the mode load, and T_MRD edges from the mode load to init_done.
- R6: With mrs_first=1 at reset, the order is close-all, the mode load, then the refreshes. The gaps are T_RP edges from close-all to the mode load, T_MRD edges from the mode load to the first refresh, and T_RC edges from the last refresh to init_done.
- R7: Every cycle that is not one of the commands above carries NOP with address zero, and this includes every cycle after init_done.
- R8: cke is high from reset onward. dqm is high from reset until init_done rises and low afterwards.
- R9: init_done and bus_grant rise on the same edge and stay high until the next reset. Changes to mrs_first or mode_cfg after that have no effect on any output.
- R10: A reset asserted part-way through the sequence restarts it from the beginning, with the full stabilization interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_first | input | 1 | Order strap sampled during reset: 1 puts the mode load ahead of the refreshes |
| mode_cfg | input | ADDR_W | Value driven on the address bus by the mode-register load |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | SDRAM address bus |
| ba | output | 1 | Bank select bit |
| dqm | output | 1 | Data mask, high while initialization runs |
| init_done | output | 1 | Sequence finished, sticky until reset |
| bus_grant | output | 1 | Command bus handed to the downstream controller |

## Verification
The sequence runs with both settings of the order strap. The bench uses a mode word that has the auto-precharge address bit set, so a mode load cannot be mistaken for close-all and a shifted gap shows up on the exact cycle. After completion the bench flips the strap and the mode word, which shows whether the block samples them only in reset. A run that is cut short by reset and followed by a full run separates a true restart from a sequence that resumes where it stopped. In each run the refresh commands are counted on the bus, so a missing refresh or an extra one is reported.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command presented on the SDRAM control pins
    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_REF  = 2'd2,
        CMD_MRS  = 2'd3
    } cmd_e;

    // Which step the sequencer will perform when its wait counter expires
    typedef enum logic [2:0] {
        PH_PALL = 3'd0,
        PH_REF  = 3'd1,
        PH_MRS  = 3'd2,
        PH_FIN  = 3'd3,
        PH_IDLE = 3'd4
    } phase_e;

endpackage

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    always_comb begin
        cs_n = 1'b0;
        unique case (cmd)
            CMD_PALL: {ras_n, cas_n, we_n} = 3'b010;
            CMD_REF:  {ras_n, cas_n, we_n} = 3'b001;
            CMD_MRS:  {ras_n, cas_n, we_n} = 3'b000;
            default:  {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end

endmodule

// File: rtl/sdram_init_gap.sv
module sdram_init_gap
    import sdram_init_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RC  = 7,
    parameter int T_MRD = 2,
    parameter int CNT_W = 8
) (
    input  cmd_e             cmd,
    output logic [CNT_W-1:0] load
);

    // Counter value loaded when a command issues: spacing to the next step minus one
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

    always_comb begin
        unique case (cmd)
            CMD_PALL: load = LD_RP;
            CMD_REF:  load = LD_RC;
            CMD_MRS:  load = LD_MRD;
            default:  load = '0;
        endcase
    end

endmodule

// File: rtl/sdram_init_order.sv
module sdram_init_order
    import sdram_init_pkg::*;
#(
    parameter int N_REFRESH = 8,
    parameter int REF_W     = 4
) (
    input  phase_e             phase,
    input  logic               mrs_early,
    input  logic [REF_W-1:0]   refs_done,
    output phase_e             phase_next
);

    localparam logic [REF_W-1:0] LAST_REF = REF_W'(N_REFRESH - 1);

    logic last_ref;
    assign last_ref = (refs_done == LAST_REF);

    always_comb begin
        unique case (phase)
            PH_PALL: phase_next = mrs_early ? PH_MRS : PH_REF;
            PH_MRS:  phase_next = mrs_early ? PH_REF : PH_FIN;
            PH_REF: begin
                if (!last_ref)      phase_next = PH_REF;
                else if (mrs_early) phase_next = PH_FIN;
                else                phase_next = PH_MRS;
            end
            default: phase_next = PH_IDLE;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int STABLE_US = 200,
    parameter int N_REFRESH = 8,
    parameter int T_RP      = 3,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_first,
    input  logic [ADDR_W-1:0] mode_cfg,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              ba,
    output logic              dqm,
    output logic              init_done,
    output logic              bus_grant
);

    localparam int STABLE_CYC = STABLE_US * CLK_MHZ;
    localparam int MAX_T1     = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int MAX_T2     = (MAX_T1 > T_MRD) ? MAX_T1 : T_MRD;
    localparam int MAX_WAIT   = (STABLE_CYC > MAX_T2) ? STABLE_CYC : MAX_T2;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);
    localparam int REF_W      = $clog2(N_REFRESH + 1);

    localparam logic [CNT_W-1:0]  STABLE_LD = CNT_W'(STABLE_CYC - 1);
    localparam logic [ADDR_W-1:0] AP_MASK   = ADDR_W'(1) << AP_BIT;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  refs;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic              order;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    cmd_e             issue_cmd;
    logic [CNT_W-1:0] gap_load;
    phase_e           phase_after;

    // Command that the current phase issues when the counter reaches zero
    always_comb begin
        unique case (s_q.phase)
            PH_PALL: issue_cmd = CMD_PALL;
            PH_REF:  issue_cmd = CMD_REF;
            PH_MRS:  issue_cmd = CMD_MRS;
            default: issue_cmd = CMD_NOP;
        endcase
    end

    sdram_init_gap #(
        .T_RP  (T_RP),
        .T_RC  (T_RC),
        .T_MRD (T_MRD),
        .CNT_W (CNT_W)
    ) u_gap (
        .cmd  (issue_cmd),
        .load (gap_load)
    );

    sdram_init_order #(
        .N_REFRESH (N_REFRESH),
        .REF_W     (REF_W)
    ) u_order (
        .phase      (s_q.phase),
        .mrs_early  (s_q.order),
        .refs_done  (s_q.refs),
        .phase_next (phase_after)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.addr = '0;
        if (s_q.phase != PH_IDLE) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                s_d.cmd   = issue_cmd;
                s_d.cnt   = gap_load;
                s_d.phase = phase_after;
                unique case (s_q.phase)
                    PH_PALL: s_d.addr = AP_MASK;
                    PH_MRS:  s_d.addr = mode_cfg;
                    PH_REF:  s_d.refs = s_q.refs + 1'b1;
                    PH_FIN:  s_d.done = 1'b1;
                    default: s_d.addr = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_PALL;
            s_q.cnt   <= STABLE_LD;
            s_q.refs  <= '0;
            s_q.cmd   <= CMD_NOP;
            s_q.addr  <= '0;
            s_q.order <= mrs_first;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    sdram_init_cmd_enc u_enc (
        .cmd   (s_q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    assign addr      = s_q.addr;
    assign ba        = 1'b0;
    assign cke       = 1'b1;
    assign dqm       = ~s_q.done;
    assign init_done = s_q.done;
    assign bus_grant = s_q.done;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int CLK_MHZ   = 100,
    parameter int STABLE_US = 200,
    parameter int N_REFRESH = 8,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mode_cfg,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ba,
    input logic              dqm,
    input logic              init_done,
    input logic              bus_grant
);

    localparam int STABLE_CYC = STABLE_US * CLK_MHZ;
    localparam int SW         = $clog2(STABLE_CYC + 1);
    localparam int RW         = $clog2(N_REFRESH + 2);

    logic is_nop, is_pall, is_ref, is_mrs;
    assign is_nop  = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
    assign is_pall = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
    assign is_ref  = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
    assign is_mrs  = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

    logic [SW-1:0] since_q;
    logic [RW-1:0] ref_seen_q;
    logic          mrs_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q    <= '0;
            ref_seen_q <= '0;
            mrs_seen_q <= 1'b0;
        end else begin
            if (since_q != SW'(STABLE_CYC)) since_q <= since_q + 1'b1;
            if (is_ref && ref_seen_q != RW'(N_REFRESH + 1)) ref_seen_q <= ref_seen_q + 1'b1;
            if (is_mrs) mrs_seen_q <= 1'b1;
        end
    end

    p_nop_while_settling_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < SW'(STABLE_CYC)) |-> is_nop);

    p_pall_ap_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> addr[AP_BIT]);

    p_refresh_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ref_seen_q == RW'(N_REFRESH)));

    p_mode_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (addr == mode_cfg && ba == 1'b0));

    p_single_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> !mrs_seen_q);

    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

    p_mask_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> dqm);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_grant_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant == init_done);

endmodule

bind sdram_init_seq sdram_init_chk #(
    .CLK_MHZ   (CLK_MHZ),
    .STABLE_US (STABLE_US),
    .N_REFRESH (N_REFRESH),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cfg  (mode_cfg),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .dqm       (dqm),
    .init_done (init_done),
    .bus_grant (bus_grant)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int STABLE_US  = 40;
    localparam int N_REFRESH  = 8;
    localparam int T_RP       = 3;
    localparam int T_RC       = 7;
    localparam int T_MRD      = 2;
    localparam int ADDR_W     = 12;
    localparam int AP_BIT     = 10;
    localparam int STABLE_CYC = STABLE_US * CLK_MHZ;
    localparam int TAIL       = 20;
    localparam int WD_CYCLES  = 20000;

    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_PALL = 4'b0010;
    localparam logic [3:0] C_REF  = 4'b0001;
    localparam logic [3:0] C_MRS  = 4'b0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mrs_first = 1'b0;
    logic [ADDR_W-1:0] mode_cfg = '0;
    logic              cke, cs_n, ras_n, cas_n, we_n, ba, dqm, init_done, bus_grant;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int failures = 0;

    logic [3:0]        q_cmd[$];
    logic [ADDR_W-1:0] q_addr[$];
    bit                q_done[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ   (CLK_MHZ),
        .STABLE_US (STABLE_US),
        .N_REFRESH (N_REFRESH),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .T_MRD     (T_MRD),
        .ADDR_W    (ADDR_W),
        .AP_BIT    (AP_BIT)
    ) u_sdram_init_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrs_first (mrs_first),
        .mode_cfg  (mode_cfg),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .dqm       (dqm),
        .init_done (init_done),
        .bus_grant (bus_grant)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a, input bit d);
        q_cmd.push_back(c);
        q_addr.push_back(a);
        q_done.push_back(d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) push(C_NOP, '0, 1'b0);
    endtask

    // Reference timeline: one entry per rising edge after reset release
    task automatic build(input bit early, input logic [ADDR_W-1:0] mode);
        q_cmd.delete();
        q_addr.delete();
        q_done.delete();
        idle(STABLE_CYC - 1);
        push(C_PALL, ADDR_W'(1) << AP_BIT, 1'b0);
        idle(T_RP - 1);
        if (early) begin
            push(C_MRS, mode, 1'b0);
            idle(T_MRD - 1);
        end
        for (int r = 0; r < N_REFRESH; r++) begin
            push(C_REF, '0, 1'b0);
            idle(T_RC - 1);
        end
        if (!early) begin
            push(C_MRS, mode, 1'b0);
            idle(T_MRD - 1);
        end
        for (int k = 0; k < TAIL; k++) push(C_NOP, '0, 1'b1);
    endtask

    function automatic string tag_of(input logic [3:0] c, input string run_tag);
        case (c)
            C_PALL:  return "R2";
            C_REF:   return "R3";
            C_MRS:   return "R4";
            default: return run_tag;
        endcase
    endfunction

    task automatic run_seq(input bit early, input logic [ADDR_W-1:0] mode,
                           input int limit, input string run_tag);
        int n;
        int refs;
        int first_cmd;
        bit flipped;
        logic [3:0] code;
        @(negedge clk);
        rst_n = 1'b0;
        mrs_first = early;
        mode_cfg = mode;
        repeat (3) @(negedge clk);
        // Reset state (R8, R7, R9)
        chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R7", "reset cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
        chk(cke == 1'b1, "R8", "reset cke", cke, 1);
        chk(dqm == 1'b1, "R8", "reset dqm", dqm, 1);
        chk(init_done == 1'b0 && bus_grant == 1'b0, "R9", "reset done", init_done, 0);
        build(early, mode);
        rst_n = 1'b1;
        n = (limit < q_cmd.size()) ? limit : q_cmd.size();
        refs = 0;
        first_cmd = -1;
        flipped = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            code = {cs_n, ras_n, cas_n, we_n};
            if (code != C_NOP && first_cmd < 0) first_cmd = i;
            if (code == C_REF) refs++;
            chk(code == q_cmd[i], tag_of(q_cmd[i], run_tag), "cmd", code, q_cmd[i]);
            chk(addr == q_addr[i], tag_of(q_cmd[i], run_tag), "addr", addr, q_addr[i]);
            chk(ba == 1'b0, "R4", "bank bit", ba, 0);
            chk(init_done == q_done[i], "R9", "init_done", init_done, q_done[i]);
            chk(bus_grant == q_done[i], "R9", "bus_grant", bus_grant, q_done[i]);
            chk(dqm == !q_done[i], "R8", "dqm", dqm, !q_done[i]);
            chk(cke == 1'b1, "R8", "cke", cke, 1);
            // Once done, disturb the configuration inputs: outputs must not react (R9)
            if (q_done[i] && !flipped) begin
                mrs_first = ~early;
                mode_cfg = ~mode;
                flipped = 1'b1;
            end
        end
        if (n > STABLE_CYC) begin
            // R1: first command on the STABLE_CYC-th edge (index STABLE_CYC-1)
            chk(first_cmd == STABLE_CYC - 1, "R1", "first command edge", first_cmd, STABLE_CYC - 1);
        end
        if (n == q_cmd.size()) begin
            chk(refs == N_REFRESH, "R3", "refresh count", refs, N_REFRESH);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R5: mode load after the refreshes; mode word has the AP bit set
        run_seq(1'b0, 12'h437, 100000, "R5");
        // R6: mode load ahead of the refreshes
        run_seq(1'b1, 12'h5a3, 100000, "R6");
        // R10: cut short inside the refresh train, then a full restart
        run_seq(1'b0, 12'h022, STABLE_CYC + 20, "R10");
        run_seq(1'b0, 12'h022, 100000, "R10");
        // R6 again with the other mode word, after a run of the opposite order
        run_seq(1'b1, 12'h437, 100000, "R6");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule